// File: doc/BRIEF.md
# USB Host Receive Babble Guard

This block sits between the receive datapath of a full-speed USB host and the packet FIFO that software drains. It sees every received byte and every end-of-packet marker, and it runs the host frame timer itself. From these it catches two faults.

The first fault is a device that sends more bytes than the channel's maximum packet size allows. The block stops storing that packet's bytes and waits for the packet to end. It then removes the whole packet from the FIFO and raises a sticky babble interrupt. The second fault is receive data that is still arriving in the guard window just before the next start of frame. The block empties the whole FIFO, drops the port-enabled state, holds the token-enable output low and raises a sticky port-disable interrupt.

The FIFO write side is speculative. A packet's bytes become visible to the reader only when the packet closes cleanly. A packet that fails is undone by moving the write pointer back to the last committed position. An external overcurrent input can also disable the port, and a separate cause bit records that case so software can tell it apart from babble. Only the synchronous soft reset input re-enables the port.

Top module: `usb_rx_babble_guard`

## Requirements
- R1: After `rst` or `soft_rst` the block is in its idle state: `port_enabled`=1, `token_en`=1, `fifo_count`=0, `sof_req`=0, `late_window`=0, and `irq_babble`, `irq_port_dis` and `ovc_cause` are all 0.
- R2: `sof_req` is a one-cycle pulse. The first pulse comes exactly `frame_interval` cycles after reset is released, and each later pulse comes `frame_interval` cycles after the one before. This needs `frame_interval` of at least 2.
- R3: `late_window` is high for exactly the `guard_len` cycles just before each `sof_req` pulse, and it is low in the pulse cycle. `token_en` is low whenever `late_window` is high. This needs 1 <= `guard_len` < `frame_interval`.
- R4: A data byte is a cycle with `rx_valid`=1 and `rx_eop`=0; any `rx_valid` in a cycle with `rx_eop`=1 is ignored. A packet of at most `max_pkt` bytes is committed by its `rx_eop` cycle. `fifo_count` shows it on the next cycle, and the reader gets its bytes in arrival order.
- R5: The data byte that would make a packet longer than `max_pkt` marks the packet as babbling. That byte and every later byte of the packet are not stored.
- R6: At the `rx_eop` of a babbling packet, all of that packet's stored bytes are discarded, data committed earlier is kept, and `irq_babble` is set.
- R7: Bytes of a packet that has not yet ended are not counted in `fifo_count`.
- R8: A data byte that arrives while `late_window`=1 and the port is enabled causes port babble. On the next cycle the FIFO is empty (committed data included), `port_enabled`=0, `irq_port_dis`=1 and `ovc_cause` is unchanged.
- R9: While the port is disabled, `token_en` stays 0 and received bytes and `rx_eop` are ignored. `fifo_count` does not change because of them.
- R10: `overcurrent`=1 while the port is enabled clears `port_enabled` and sets `irq_port_dis` and `ovc_cause` on the next cycle. FIFO contents are kept.
- R11: `irq_clr` is write-one-to-clear. Bit 0 clears `irq_babble`; bit 1 clears `irq_port_dis` and `ovc_cause`. A set event in the same cycle wins over the clear.
- R12: `soft_rst` is the only way `port_enabled` goes from 0 to 1. It also empties the FIFO and restarts the frame timer.
- R13: A data byte that meets a full FIFO, in a packet still within `max_pkt`, marks the packet as overflowed. At its `rx_eop` the packet is discarded without setting `irq_babble`.
- R14: A cycle with `rd_en`=1 and `fifo_count`>0 pops one byte. That byte appears on `rd_data` with `rd_valid`=1 on the next cycle. `rd_valid` is 0 in a cycle that follows no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous soft reset; re-enables the port |
| frame_interval | input | FW (14) | Frame length in clock cycles |
| guard_len | input | FW (14) | Length of the late-frame guard window in cycles |
| max_pkt | input | CW (11) | Maximum packet size of the current channel in bytes |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | DW (8) | Received byte |
| rx_eop | input | 1 | End-of-packet marker; carries no data |
| rd_en | input | 1 | Reader pop request |
| rd_data | output | DW (8) | Popped byte, registered |
| rd_valid | output | 1 | `rd_data` holds a byte popped in the previous cycle |
| fifo_count | output | AW+1 (7) | Committed bytes available to the reader |
| overcurrent | input | 1 | Overcurrent indication from the port power switch |
| irq_clr | input | 2 | Write-one-to-clear pulses: bit 0 babble, bit 1 port disable |
| sof_req | output | 1 | One-cycle start-of-frame request |
| late_window | output | 1 | End-of-frame guard window is active |
| token_en | output | 1 | Token issue permitted |
| port_enabled | output | 1 | Port is enabled |
| irq_babble | output | 1 | Sticky packet babble interrupt |
| irq_port_dis | output | 1 | Sticky port-disable interrupt |
| ovc_cause | output | 1 | Sticky flag: the port was disabled by overcurrent |

## Verification
Every byte, `rx_eop`, `overcurrent`, `irq_clr` or `soft_rst` input is taken at one rising edge, and its effect is due at the ports one cycle later. The bench drives these inputs on the falling edge and samples the result on the next falling edge. A pop shows its byte on the falling edge after the rising edge that accepted `rd_en`. Frame results are counted in whole cycles from the `sof_req` falling edge. At that edge the timer is at count 0, so the k-th cycle after it stands at count k, and the bench places bytes in or out of the guard window by counting falling edges from the pulse.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

  // Disposition of the packet currently being received.
  typedef enum logic [1:0] {
    PK_GOOD   = 2'd0,  // bytes are being stored
    PK_BABBLE = 2'd1,  // size limit exceeded, rest dropped
    PK_OVFL   = 2'd2   // FIFO ran full, rest dropped
  } pkt_state_e;

  // Write-side commands from the packet monitor to the FIFO.
  typedef struct packed {
    logic push;
    logic commit;
    logic rollback;
  } fifo_cmd_t;

endpackage

// File: rtl/rxg_frame_timer.sv
module rxg_frame_timer #(
  parameter int FW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] interval,
  input  logic [FW-1:0] guard,
  output logic          sof_req,
  output logic          late_window
);

  logic [FW-1:0] cnt;
  logic [FW-1:0] cnt_nxt;
  logic          wrap;

  // The counter runs from 0 to interval-1. The >= compare also covers
  // an interval that is lowered while the counter is above it.
  always_comb begin
    wrap    = (cnt >= interval - 1'b1);
    cnt_nxt = wrap ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      sof_req     <= 1'b0;
      late_window <= 1'b0;
    end else begin
      cnt         <= cnt_nxt;
      sof_req     <= wrap;
      late_window <= (cnt_nxt >= interval - guard);
    end
  end

endmodule

// File: rtl/rxg_fifo.sv
module rxg_fifo #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  rxg_pkg::fifo_cmd_t cmd,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          full,
  output logic [AW:0]   count
);

  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp_spec;
  logic [AW:0]   wp_com;
  logic [AW:0]   rp;
  logic          do_wr;
  logic          do_rd;

  always_comb begin
    full  = ((wp_spec - rp) == DEPTH_V);
    count = wp_com - rp;
    do_wr = cmd.push & ~full;
    do_rd = rd_en & (count != '0);
  end

  // Storage without reset so that it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_spec[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rp[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp_spec  <= '0;
      wp_com   <= '0;
      rp       <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rp <= rp + 1'b1;
      if (cmd.rollback)  wp_spec <= wp_com;
      else if (do_wr)    wp_spec <= wp_spec + 1'b1;
      if (cmd.commit)    wp_com  <= wp_spec;
    end
  end

endmodule

// File: rtl/rxg_pkt_monitor.sv
module rxg_pkt_monitor #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_in,
  input  logic          eop_in,
  input  logic [CW-1:0] max_pkt,
  input  logic          fifo_full,
  output rxg_pkg::fifo_cmd_t cmd,
  output logic          babble_evt
);

  import rxg_pkg::*;

  pkt_state_e    st;
  logic [CW-1:0] nbytes;
  logic          over;

  always_comb begin
    over         = (nbytes >= max_pkt);
    cmd.push     = byte_in & (st == PK_GOOD) & ~over & ~fifo_full;
    cmd.commit   = eop_in & (st == PK_GOOD);
    cmd.rollback = eop_in & (st != PK_GOOD);
    babble_evt   = eop_in & (st == PK_BABBLE);
  end

  always_ff @(posedge clk) begin
    if (rst || eop_in) begin
      st     <= PK_GOOD;
      nbytes <= '0;
    end else if (byte_in && st == PK_GOOD) begin
      if (over)           st     <= PK_BABBLE;
      else if (fifo_full) st     <= PK_OVFL;
      else                nbytes <= nbytes + 1'b1;
    end
  end

endmodule

// File: rtl/usb_rx_babble_guard.sv
module usb_rx_babble_guard #(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int CW = 11,
  parameter int FW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic [FW-1:0] frame_interval,
  input  logic [FW-1:0] guard_len,
  input  logic [CW-1:0] max_pkt,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_eop,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW:0]   fifo_count,
  input  logic          overcurrent,
  input  logic [1:0]    irq_clr,
  output logic          sof_req,
  output logic          late_window,
  output logic          token_en,
  output logic          port_enabled,
  output logic          irq_babble,
  output logic          irq_port_dis,
  output logic          ovc_cause
);

  import rxg_pkg::*;

  logic      srst;
  logic      byte_ok;
  logic      port_babble;
  logic      byte_in;
  logic      eop_in;
  logic      ovc_evt;
  logic      babble_evt;
  logic      fifo_full;
  fifo_cmd_t cmd;

  always_comb begin
    srst        = rst | soft_rst;
    byte_ok     = rx_valid & ~rx_eop & port_enabled;
    port_babble = byte_ok & late_window;
    byte_in     = byte_ok & ~late_window;
    eop_in      = rx_eop & port_enabled;
    ovc_evt     = overcurrent & port_enabled;
    token_en    = port_enabled & ~late_window;
  end

  rxg_frame_timer #(.FW(FW)) u_timer (
    .clk        (clk),
    .rst        (srst),
    .interval   (frame_interval),
    .guard      (guard_len),
    .sof_req    (sof_req),
    .late_window(late_window)
  );

  rxg_pkt_monitor #(.CW(CW)) u_mon (
    .clk       (clk),
    .rst       (srst | port_babble),
    .byte_in   (byte_in),
    .eop_in    (eop_in),
    .max_pkt   (max_pkt),
    .fifo_full (fifo_full),
    .cmd       (cmd),
    .babble_evt(babble_evt)
  );

  rxg_fifo #(.DW(DW), .AW(AW)) u_fifo (
    .clk     (clk),
    .rst     (srst),
    .flush   (port_babble),
    .cmd     (cmd),
    .wdata   (rx_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .rd_valid(rd_valid),
    .full    (fifo_full),
    .count   (fifo_count)
  );

  // Port state and sticky interrupts; a set event wins over a clear.
  always_ff @(posedge clk) begin
    if (srst) begin
      port_enabled <= 1'b1;
      irq_babble   <= 1'b0;
      irq_port_dis <= 1'b0;
      ovc_cause    <= 1'b0;
    end else begin
      if (port_babble || ovc_evt) port_enabled <= 1'b0;
      irq_babble   <= babble_evt | (irq_babble & ~irq_clr[0]);
      irq_port_dis <= port_babble | ovc_evt | (irq_port_dis & ~irq_clr[1]);
      ovc_cause    <= ovc_evt | (ovc_cause & ~irq_clr[1]);
    end
  end

endmodule

// File: rtl/rxg_checker.sv
module rxg_checker #(
  parameter int AW = 6
) (
  input logic        clk,
  input logic        rst,
  input logic        soft_rst,
  input logic        rx_valid,
  input logic        rx_eop,
  input logic        rd_en,
  input logic        rd_valid,
  input logic        overcurrent,
  input logic        sof_req,
  input logic        late_window,
  input logic        token_en,
  input logic        port_enabled,
  input logic        irq_babble,
  input logic        ovc_cause,
  input logic        irq_port_dis,
  input logic [AW:0] fifo_count
);

  localparam logic [AW:0] DEPTH_V = (AW+1)'(1 << AW);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= DEPTH_V);

  assert_sof_pulse_R2: assert property (@(posedge clk) disable iff (rst || soft_rst)
    sof_req |=> !sof_req);

  assert_quiet_window_R3: assert property (@(posedge clk) disable iff (rst || soft_rst)
    late_window |-> !token_en);

  assert_port_babble_R8: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (rx_valid && !rx_eop && late_window && port_enabled) |=>
      (!port_enabled && fifo_count == '0 && irq_port_dis));

  assert_babble_at_eop_R6: assert property (@(posedge clk) disable iff (rst || soft_rst)
    $rose(irq_babble) |-> $past(rx_eop));

  assert_no_token_R9: assert property (@(posedge clk) disable iff (rst || soft_rst)
    !port_enabled |-> !token_en);

  assert_ovc_cause_R10: assert property (@(posedge clk) disable iff (rst || soft_rst)
    $rose(ovc_cause) |-> $past(overcurrent));

  assert_reenable_R12: assert property (@(posedge clk) disable iff (rst)
    (port_enabled && !$past(port_enabled)) |-> ($past(soft_rst) || $past(rst)));

  assert_rd_valid_R14: assert property (@(posedge clk) disable iff (rst || soft_rst)
    rd_valid |-> $past(rd_en));

endmodule

bind usb_rx_babble_guard rxg_checker #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .soft_rst    (soft_rst),
  .rx_valid    (rx_valid),
  .rx_eop      (rx_eop),
  .rd_en       (rd_en),
  .rd_valid    (rd_valid),
  .overcurrent (overcurrent),
  .sof_req     (sof_req),
  .late_window (late_window),
  .token_en    (token_en),
  .port_enabled(port_enabled),
  .irq_babble  (irq_babble),
  .ovc_cause   (ovc_cause),
  .irq_port_dis(irq_port_dis),
  .fifo_count  (fifo_count)
);

// File: tb/sim_usb_rx_babble_guard.sv
module sim_usb_rx_babble_guard;

  localparam int DW = 8, AW = 6, CW = 11, FW = 14;
  localparam int INTERVAL = 120;
  localparam int GUARD = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          soft_rst = 1'b0;
  logic [FW-1:0] frame_interval = FW'(INTERVAL);
  logic [FW-1:0] guard_len = FW'(GUARD);
  logic [CW-1:0] max_pkt = CW'(16);
  logic          rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          rx_eop = 1'b0;
  logic          rd_en = 1'b0;
  logic          overcurrent = 1'b0;
  logic [1:0]    irq_clr = 2'b00;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic [AW:0]   fifo_count;
  logic          sof_req, late_window, token_en, port_enabled;
  logic          irq_babble, irq_port_dis, ovc_cause;

  always #4 clk = ~clk;

  usb_rx_babble_guard #(.DW(DW), .AW(AW), .CW(CW), .FW(FW)) u0 (.*);

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] pkt_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  function automatic bit fits(input int n, input int lim);
    return n <= lim;
  endfunction

  task automatic wait_sof();
    do @(negedge clk); while (sof_req !== 1'b1);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Sends n bytes and an end marker. The bytes go to pkt_q. The R7 check
  // looks at the count halfway through the packet.
  task automatic send_pkt(input int n);
    int committed;
    committed = exp_q.size();
    pkt_q.delete();
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_data  = 8'($urandom);
      pkt_q.push_back(rx_data);
      @(negedge clk);
      if (i == n / 2) chk("R7 count excludes open packet", 32'(fifo_count), 32'(committed));
    end
    rx_valid = 1'b0;
    rx_eop   = 1'b1;
    @(negedge clk);
    rx_eop   = 1'b0;
  endtask

  task automatic keep_pkt();
    foreach (pkt_q[i]) exp_q.push_back(pkt_q[i]);
  endtask

  task automatic drain(input string req);
    logic [7:0] e;
    chk(req, 32'(fifo_count), 32'(exp_q.size()));
    while (exp_q.size() > 0) begin
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      e = exp_q.pop_front();
      chk("R14 read data", {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, e});
    end
    @(negedge clk);
    chk("R14 no pop no valid", 32'(rd_valid), 32'd0);
  endtask

  task automatic clr_irq(input logic [1:0] v);
    irq_clr = v;
    @(negedge clk);
    irq_clr = 2'b00;
  endtask

  task automatic do_soft_reset();
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int k, lates, badtok;
    int mx, n;
    void'($urandom(32'd20240611));
    idle(5);
    rst = 1'b0;

    // R1: state right after reset
    chk("R1 port_enabled", 32'(port_enabled), 32'd1);
    chk("R1 token_en", 32'(token_en), 32'd1);
    chk("R1 fifo_count", 32'(fifo_count), 32'd0);
    chk("R1 irqs", {29'd0, irq_babble, irq_port_dis, ovc_cause}, 32'd0);
    chk("R1 sof/late", {30'd0, sof_req, late_window}, 32'd0);

    // R2: first pulse and frame period
    k = 0;
    do begin @(negedge clk); k++; end while (sof_req !== 1'b1 && k < 1000);
    chk("R2 first sof", 32'(k), 32'(INTERVAL));
    for (int f = 0; f < 2; f++) begin
      k = 0; lates = 0; badtok = 0;
      do begin
        @(negedge clk); k++;
        if (late_window) lates++;
        if (late_window && token_en) badtok++;
      end while (sof_req !== 1'b1 && k < 1000);
      chk("R2 period", 32'(k), 32'(INTERVAL));
      chk("R3 guard length", 32'(lates), 32'(GUARD));
      chk("R3 token low in guard", 32'(badtok), 32'd0);
      chk("R3 late low at sof", 32'(late_window), 32'd0);
    end

    // R4 / R5 / R6 boundary: exactly max good, max+1 babbles
    max_pkt = CW'(16);
    wait_sof(); send_pkt(16); keep_pkt();
    chk("R4 exact max committed", 32'(fifo_count), 32'd16);
    drain("R4 drain exact");
    wait_sof(); send_pkt(5); keep_pkt();
    send_pkt(17);
    chk("R5 babble drops packet", 32'(fifo_count), 32'd5);
    chk("R6 irq_babble set", 32'(irq_babble), 32'd1);
    drain("R6 earlier data kept");
    clr_irq(2'b01);
    chk("R11 babble cleared", 32'(irq_babble), 32'd0);

    // Random sizes against random limits
    for (int it = 0; it < 30; it++) begin
      mx = 8 + int'($urandom % 41);
      n  = 1 + int'($urandom % (mx + 6));
      max_pkt = CW'(mx);
      wait_sof();
      send_pkt(n);
      if (fits(n, mx)) keep_pkt();
      chk(fits(n, mx) ? "R4 random good" : "R5 random babble", 32'(irq_babble),
          fits(n, mx) ? 32'd0 : 32'd1);
      drain("R4 random drain");
      if (irq_babble) clr_irq(2'b01);
    end

    // R13: overflow is discarded silently; a packet that exactly fills is kept
    max_pkt = CW'(70);
    wait_sof(); send_pkt(66);
    chk("R13 overflow dropped", 32'(fifo_count), 32'd0);
    chk("R13 no babble irq", 32'(irq_babble), 32'd0);
    wait_sof(); send_pkt(64); keep_pkt();
    chk("R13 full packet kept", 32'(fifo_count), 32'd64);
    drain("R13 drain full");

    // R8: port babble in the guard window
    max_pkt = CW'(32);
    wait_sof();
    send_pkt(10); keep_pkt();
    for (int i = 0; i < 5; i++) begin
      rx_valid = 1'b1; rx_data = 8'($urandom); @(negedge clk);
    end
    rx_valid = 1'b0;
    idle(INTERVAL - GUARD - 16);
    chk("R8 in guard, port on", {30'd0, late_window, port_enabled}, 32'd3);
    rx_valid = 1'b1; rx_data = 8'hA5;
    @(negedge clk);
    rx_valid = 1'b0;
    exp_q.delete();
    chk("R8 fifo flushed", 32'(fifo_count), 32'd0);
    chk("R8 port disabled", 32'(port_enabled), 32'd0);
    chk("R8 irq_port_dis", 32'(irq_port_dis), 32'd1);
    chk("R8 ovc_cause clear", 32'(ovc_cause), 32'd0);

    // R9: disabled port ignores traffic and issues no tokens
    wait_sof();
    chk("R9 token off", 32'(token_en), 32'd0);
    send_pkt(8);
    chk("R9 traffic ignored", 32'(fifo_count), 32'd0);
    chk("R9 still disabled", 32'(port_enabled), 32'd0);
    clr_irq(2'b10);
    chk("R11 port irq cleared", 32'(irq_port_dis), 32'd0);
    chk("R12 clear does not enable", 32'(port_enabled), 32'd0);

    // R12: soft reset re-enables
    do_soft_reset();
    chk("R12 port re-enabled", 32'(port_enabled), 32'd1);
    chk("R12 token on", 32'(token_en), 32'd1);
    chk("R1 soft reset count", 32'(fifo_count), 32'd0);

    // R10 / R11: overcurrent disables, keeps data; set wins over clear
    wait_sof(); send_pkt(12); keep_pkt();
    overcurrent = 1'b1; irq_clr = 2'b10;
    @(negedge clk);
    overcurrent = 1'b0; irq_clr = 2'b00;
    chk("R10 port disabled", 32'(port_enabled), 32'd0);
    chk("R11 set wins irq_port_dis", 32'(irq_port_dis), 32'd1);
    chk("R10 ovc_cause", 32'(ovc_cause), 32'd1);
    chk("R10 fifo kept", 32'(fifo_count), 32'd12);
    drain("R10 drain after ovc");
    clr_irq(2'b10);
    chk("R11 ovc cleared", {30'd0, irq_port_dis, ovc_cause}, 32'd0);
    do_soft_reset();
    chk("R12 enabled after ovc", 32'(port_enabled), 32'd1);

    idle(4);
    summary();
  end

endmodule